// File: doc/BRIEF.md
# Serial LED Chain Driver

This block drives a string of external serial-in, parallel-out shift registers that light status LEDs. It divides the system clock down to a slow serial clock, shifts one frame of bits out on a data pin and then raises a latch pin for one serial-clock period. The external registers then show the whole frame at once. The next frame starts straight after the latch period, so the LEDs are refreshed for as long as the block is enabled.

A frame is built from up to four segments, in this order:
- a header of user bits;
- a status field for each enabled port, from the lowest port number to the highest;
- an optional 17-bit debug word;
- a trailer of user bits.

Every segment is sent least significant bit first. The header and trailer bits are held in two 32-bit registers inside the block. Each of these registers can be written directly, have bits set or have bits cleared. The per-port fields arrive already formatted as a bit vector and a length for each port.

All configuration and segment data is captured at the moment a frame starts. A write made during a frame is therefore shown in the following frame.

Top module: `led_chain_ctrl`

## Requirements
- R1: While `en` is low, `led_clk`, `led_dat` and `led_lat` are all 0. Lowering `en` in the middle of a frame forces all three to 0 from the next clock, and raising it again starts a fresh frame.
- R2: Each half-period of `led_clk` lasts PRE_DIV × phase system clocks, and a `phase` of 0 is treated as 1. Every serial-clock period starts with its low half. `led_dat` changes only at a falling edge of `led_clk` or at the first cycle of an enabled run.
- R3: After the last bit of a frame, `led_lat` is 1 for exactly one serial-clock period, starting with the low half. The data bit sent during that period is 0 before inversion. The next frame's first bit follows at once.
- R4: Bits are sent in this order: the header, then each enabled port from the lowest index to the highest, then the debug word, then the trailer. Each segment is sent LSB first.
- R5: `hdr_len` and `trl_len` select how many low bits of the header and trailer registers are sent, from 0 to 32. Any value above 32 sends all 32 bits. A count of 0 sends nothing.
- R6: Port p contributes bits only when `port_en[p]` is 1. It sends the low `port_len[4p+3:4p]` bits of `port_bits[8p+7:8p]`, limited to 8 bits.
- R7: When `dbg_en` is 1, the 17 bits of `dbg_word` are sent between the port fields and the trailer. When `dbg_en` is 0 the debug word is absent from the frame.
- R8: When `pol` is 1, `led_dat` is the inverse of the chain bit, and the latch period shows 1. When `pol` is 0, `led_dat` is the chain bit.
- R9: The header register is updated by `hdr_op` with `hdr_wdata`, and the trailer register by `trl_op` with `trl_wdata`. The encodings are: 2'b00 hold, 2'b01 load the data, 2'b10 OR in the data bits, 2'b11 clear the data bits. Both registers reset to 0.
- R10: Configuration, port inputs and register contents are captured on the clock edge that starts a frame. A register operation applied on that same edge appears first in the following frame.
- R11: A frame with no bits consists of the latch period alone, so `led_lat` stays 1 continuously while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enables the serial chain |
| phase | input | 7 | Half-period length, in units of PRE_DIV clocks |
| pol | input | 1 | 1 inverts the serial data |
| dbg_en | input | 1 | Inserts the debug word into the frame |
| dbg_word | input | 17 | Debug bits |
| hdr_len | input | 6 | Header bit count |
| trl_len | input | 6 | Trailer bit count |
| hdr_op | input | 2 | Header register operation |
| hdr_wdata | input | 32 | Header operation data |
| trl_op | input | 2 | Trailer register operation |
| trl_wdata | input | 32 | Trailer operation data |
| port_en | input | 8 | Per-port enable mask |
| port_bits | input | 64 | Formatted status field per port, 8 bits each |
| port_len | input | 32 | Field length per port, 4 bits each |
| led_clk | output | 1 | Serial clock to the LED registers |
| led_dat | output | 1 | Serial data |
| led_lat | output | 1 | Parallel latch strobe |

## Verification
The case that needs care is a header or trailer register operation that lands on the very edge where a new frame captures its contents. The capture must take the old value and the operation must take effect in the register, so both happen on one edge.

The bench provokes this by watching its own model for the last cycle of a latch period and applying a set or clear operation on exactly that cycle. Its cycle model predicts the old bits in the frame being captured and the new bits in the frame after it. Any mismatch in the serial data shows up in the per-cycle comparison.

// File: rtl/led_chain_ctrl.sv
module led_chain_ctrl #(
  parameter int PORTS   = 8,
  parameter int SW      = 8,
  parameter int UDW     = 32,
  parameter int DBGW    = 17,
  parameter int PRE_DIV = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [6:0]            phase,
  input  logic                  pol,
  input  logic                  dbg_en,
  input  logic [DBGW-1:0]       dbg_word,
  input  logic [5:0]            hdr_len,
  input  logic [5:0]            trl_len,
  input  logic [1:0]            hdr_op,
  input  logic [UDW-1:0]        hdr_wdata,
  input  logic [1:0]            trl_op,
  input  logic [UDW-1:0]        trl_wdata,
  input  logic [PORTS-1:0]      port_en,
  input  logic [PORTS*SW-1:0]   port_bits,
  input  logic [PORTS*4-1:0]    port_len,
  output logic                  led_clk,
  output logic                  led_dat,
  output logic                  led_lat
);
  localparam int MAXB = 2*UDW + PORTS*SW + DBGW;
  localparam int NW   = $clog2(MAXB+1);
  localparam int CW   = $clog2(PRE_DIV*128);

  logic [UDW-1:0]  hdr_q, trl_q;
  logic [MAXB-1:0] chain, nxt;
  logic [NW-1:0]   left, nlen;
  logic [CW-1:0]   cnt;
  logic [6:0]      ph_q;
  logic            on, lclk, lat_q, pol_q;

  wire [CW-1:0] half_m1 = CW'(PRE_DIV) * CW'(ph_q) - CW'(1);
  wire          at_end  = (cnt == half_m1);
  wire          start   = en && (!on || (at_end && lclk && lat_q));

  function automatic logic [UDW-1:0] apply_op(input logic [UDW-1:0] cur,
                                              input logic [1:0] op,
                                              input logic [UDW-1:0] d);
    case (op)
      2'b01:   return d;
      2'b10:   return cur | d;
      2'b11:   return cur & ~d;
      default: return cur;
    endcase
  endfunction

  always_comb begin
    nxt  = '0;
    nlen = '0;
    for (int j = 0; j < UDW; j++)
      if (6'(j) < hdr_len) begin
        nxt[nlen] = hdr_q[j];
        nlen      = nlen + NW'(1);
      end
    for (int p = 0; p < PORTS; p++)
      if (port_en[p])
        for (int b = 0; b < SW; b++)
          if (4'(b) < port_len[p*4 +: 4]) begin
            nxt[nlen] = port_bits[p*SW + b];
            nlen      = nlen + NW'(1);
          end
    if (dbg_en)
      for (int k = 0; k < DBGW; k++) begin
        nxt[nlen] = dbg_word[k];
        nlen      = nlen + NW'(1);
      end
    for (int j = 0; j < UDW; j++)
      if (6'(j) < trl_len) begin
        nxt[nlen] = trl_q[j];
        nlen      = nlen + NW'(1);
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q <= '0;
      trl_q <= '0;
      on    <= 1'b0;
      lclk  <= 1'b0;
      lat_q <= 1'b0;
      pol_q <= 1'b0;
      ph_q  <= 7'd1;
      cnt   <= '0;
      chain <= '0;
      left  <= '0;
    end else begin
      hdr_q <= apply_op(hdr_q, hdr_op, hdr_wdata);
      trl_q <= apply_op(trl_q, trl_op, trl_wdata);
      if (!en) begin
        on    <= 1'b0;
        lclk  <= 1'b0;
        lat_q <= 1'b0;
        cnt   <= '0;
        chain <= '0;
      end else if (start) begin
        on    <= 1'b1;
        lclk  <= 1'b0;
        cnt   <= '0;
        chain <= nxt;
        left  <= nlen;
        lat_q <= (nlen == '0);
        pol_q <= pol;
        ph_q  <= (phase == 7'd0) ? 7'd1 : phase;
      end else if (at_end) begin
        cnt  <= '0;
        lclk <= ~lclk;
        if (lclk) begin
          chain <= chain >> 1;
          left  <= left - NW'(1);
          lat_q <= (left == NW'(1));
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign led_clk = lclk;
  assign led_dat = on & (chain[0] ^ pol_q);
  assign led_lat = on & lat_q;

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!led_clk && !led_dat && !led_lat));

  // R2
  dat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (on && $past(on) && !$fell(led_clk)) |-> $stable(led_dat));

  // R3
  lat_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(led_lat) |-> !led_clk);

  // R3
  lat_end_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(led_lat) && $past(en) && en) |-> $fell(led_clk));

  // R8
  lat_dat_chk: assert property (@(posedge clk) disable iff (rst)
    (led_lat && $stable(led_lat)) |-> $stable(led_dat));
endmodule

// File: tb/led_chain_ctrl_test.sv
module led_chain_ctrl_test;
  localparam int PRE = 2;

  logic        clk = 0, rst = 1, en = 0, pol = 0, dbg_en = 0;
  logic [6:0]  phase = 7'd1;
  logic [16:0] dbg_word = '0;
  logic [5:0]  hdr_len = '0, trl_len = '0;
  logic [1:0]  hdr_op = '0, trl_op = '0;
  logic [31:0] hdr_wdata = '0, trl_wdata = '0;
  logic [7:0]  port_en = '0;
  logic [63:0] port_bits = '0;
  logic [31:0] port_len = '0;
  wire         led_clk, led_dat, led_lat;

  led_chain_ctrl #(.PRE_DIV(PRE)) uut (
    .clk(clk), .rst(rst), .en(en), .phase(phase), .pol(pol), .dbg_en(dbg_en),
    .dbg_word(dbg_word), .hdr_len(hdr_len), .trl_len(trl_len),
    .hdr_op(hdr_op), .hdr_wdata(hdr_wdata), .trl_op(trl_op), .trl_wdata(trl_wdata),
    .port_en(port_en), .port_bits(port_bits), .port_len(port_len),
    .led_clk(led_clk), .led_dat(led_dat), .led_lat(led_lat));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cycle = 0;
  string cur_req = "R1";

  bit m_q[$];
  bit m_on, m_clk, m_lat, m_pol;
  int m_cnt, m_half;
  logic [31:0] m_hdr, m_trl;

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] op_f(logic [31:0] c, logic [1:0] op, logic [31:0] d);
    if (op == 2'b01) return d;
    if (op == 2'b10) return c | d;
    if (op == 2'b11) return c & ~d;
    return c;
  endfunction

  function automatic void start_frame();
    m_q.delete();
    for (int j = 0; j < 32; j++) if (j < int'(hdr_len)) m_q.push_back(m_hdr[j]);
    for (int p = 0; p < 8; p++)
      if (port_en[p])
        for (int b = 0; b < 8; b++)
          if (b < int'(port_len[p*4 +: 4])) m_q.push_back(port_bits[p*8 + b]);
    if (dbg_en) for (int k = 0; k < 17; k++) m_q.push_back(dbg_word[k]);
    for (int j = 0; j < 32; j++) if (j < int'(trl_len)) m_q.push_back(m_trl[j]);
    m_cnt  = 0;
    m_clk  = 0;
    m_pol  = pol;
    m_half = PRE * ((phase == 0) ? 1 : int'(phase));
    m_lat  = (m_q.size() == 0);
  endfunction

  always @(posedge clk) begin
    cycle++;
    if (rst) begin
      m_on = 0; m_clk = 0; m_lat = 0; m_cnt = 0; m_pol = 0; m_half = PRE;
      m_hdr = '0; m_trl = '0; m_q.delete();
    end else begin
      if (!en) begin
        m_on = 0; m_clk = 0; m_lat = 0; m_q.delete();
      end else if (!m_on) begin
        m_on = 1;
        start_frame();
      end else if (m_cnt == m_half - 1) begin
        m_cnt = 0;
        if (!m_clk) m_clk = 1;
        else begin
          m_clk = 0;
          if (m_lat) start_frame();
          else begin
            void'(m_q.pop_front());
            m_lat = (m_q.size() == 0);
          end
        end
      end else m_cnt++;
      m_hdr = op_f(m_hdr, hdr_op, hdr_wdata);
      m_trl = op_f(m_trl, trl_op, trl_wdata);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      bit ed;
      ed = m_on ? (((m_q.size() > 0) ? m_q[0] : 1'b0) ^ m_pol) : 1'b0;
      check(led_clk === (m_on & m_clk), cur_req, "led_clk", int'(led_clk), int'(m_on & m_clk));
      check(led_dat === ed, cur_req, "led_dat", int'(led_dat), int'(ed));
      check(led_lat === (m_on & m_lat), cur_req, "led_lat", int'(led_lat), int'(m_on & m_lat));
    end
  end

  always @(posedge clk) begin
    if (cycle == 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cycle, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure_period(int exp, string req);
    int t0;
    while (led_clk !== 1'b0) @(negedge clk);
    while (led_clk !== 1'b1) @(negedge clk);
    t0 = cycle;
    while (led_clk !== 1'b0) @(negedge clk);
    while (led_clk !== 1'b1) @(negedge clk);
    check((cycle - t0) == exp, req, "led_clk period", cycle - t0, exp);
  endtask

  task automatic wait_frame_edge();
    @(negedge clk);
    while (!(m_on && m_lat && m_clk && m_cnt == m_half - 1)) @(negedge clk);
  endtask

  initial begin
    int t0;
    cyc(3);
    check({led_clk, led_dat, led_lat} === 3'b000, "R1", "outputs in reset", int'({led_clk, led_dat, led_lat}), 0);
    rst = 0;

    cur_req = "R9";
    hdr_op = 2'b01; hdr_wdata = 32'h0000_0015;
    trl_op = 2'b01; trl_wdata = 32'h0000_0005;
    cyc(1);
    hdr_op = 2'b00; trl_op = 2'b00;

    cur_req = "R4";
    hdr_len = 6'd5; trl_len = 6'd3;
    port_en = 8'b0010_0101; port_len = 32'h0060_0402;
    port_bits = 64'hA5C3_9E17_4B2D_F086;
    dbg_en = 1; dbg_word = 17'h1A5C3;
    en = 1;
    cyc(1500);

    cur_req = "R3";
    while (led_lat !== 1'b1) @(negedge clk);
    t0 = cycle;
    while (led_lat !== 1'b0) @(negedge clk);
    check((cycle - t0) == 2*PRE, "R3", "latch width", cycle - t0, 2*PRE);

    cur_req = "R7";
    dbg_en = 0;
    cyc(1000);

    cur_req = "R6";
    port_en = 8'b1000_0011; port_len = 32'hF000_00F8;
    cyc(1500);

    cur_req = "R2";
    phase = 7'd3;
    cyc(1500);
    measure_period(2*PRE*3, "R2");
    phase = 7'd0;
    cyc(1500);
    measure_period(2*PRE, "R2");
    phase = 7'd1;

    cur_req = "R8";
    pol = 1;
    cyc(800);
    while (led_lat !== 1'b1) @(negedge clk);
    check(led_dat === 1'b1, "R8", "inverted latch data", int'(led_dat), 1);
    cyc(600);
    pol = 0;

    cur_req = "R5";
    hdr_op = 2'b01; hdr_wdata = 32'hFFFF_FFFF; cyc(1); hdr_op = 2'b00;
    hdr_len = 6'd40; trl_len = 6'd0;
    cyc(2500);
    hdr_len = 6'd32; trl_len = 6'd33;
    trl_op = 2'b01; trl_wdata = 32'h8000_0001; cyc(1); trl_op = 2'b00;
    cyc(2500);

    cur_req = "R9";
    hdr_len = 6'd12; trl_len = 6'd12;
    cyc(100);
    hdr_op = 2'b10; hdr_wdata = 32'h0000_0F00; cyc(1);
    hdr_op = 2'b11; hdr_wdata = 32'h0000_00F0; cyc(1);
    hdr_op = 2'b00; cyc(200);
    trl_op = 2'b11; trl_wdata = 32'h0000_0FFF; cyc(1);
    trl_op = 2'b10; trl_wdata = 32'h0000_0A5A; cyc(1);
    trl_op = 2'b00;
    cyc(1200);

    cur_req = "R10";
    wait_frame_edge();
    hdr_op = 2'b11; hdr_wdata = 32'h0000_0AAA;
    trl_op = 2'b10; trl_wdata = 32'h0000_0555;
    cyc(1);
    hdr_op = 2'b00; trl_op = 2'b00;
    cyc(1500);
    wait_frame_edge();
    phase = 7'd2; pol = 1; hdr_len = 6'd7;
    cyc(2500);
    phase = 7'd1; pol = 0;

    cur_req = "R1";
    cyc(57);
    en = 0;
    cyc(3);
    check({led_clk, led_dat, led_lat} === 3'b000, "R1", "outputs while disabled", int'({led_clk, led_dat, led_lat}), 0);
    cyc(40);
    en = 1;
    cyc(800);

    cur_req = "R11";
    hdr_len = 0; trl_len = 0; port_en = 0; dbg_en = 0;
    cyc(800);
    check(led_lat === 1'b1, "R11", "latch held for empty frame", int'(led_lat), 1);
    cyc(100);
    check(led_lat === 1'b1, "R11", "latch still held", int'(led_lat), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule